// File: doc/BRIEF.md
# Power-Management Clock Gating Window

This block decides when the internal clock grids of two clock domains may be gated. Upstream logic decodes power-management broadcast messages and presents each one for a single cycle as an event, which the block watches. Each event carries a kind and a 3-bit system-management action field. A stop-grant event whose action field equals a domain's programmed match value arms that domain's gating window. A resume event, which signals that the clock-stop request has been withdrawn, disarms the windows of all domains. Domain 0 covers the core clock grids. Domain 1 covers the expansion-bus clock and its grids.

An external stop-link pin is active low and asynchronous to the block clock. It passes through a two-flop synchronizer. A domain's gate-enable output is high only while that domain's window is armed and the synchronized stop-link request is active. Dropping the stop-link request ungates the clock without disarming the window, so a later stop-link assertion gates again without a new broadcast. Each match value is loaded through a small write port. Packet decoding and the clock gate cells are outside this block.

Top module: `pmcg_gate_window`

## Requirements
- R1: While `rst_n` is low, and after it is released, both windows are disarmed, `gate_en` is 2'b00, both match values are 0 and the synchronizer holds "stop inactive".
- R2: An event with `bcast_valid`=1 and `bcast_kind`=2'b01 (stop-grant) whose `bcast_action` equals a domain's match value arms that domain's window at the next clock edge. If stop is already active, that domain's `gate_en` bit is high after that same edge.
- R3: A stop-grant whose action field differs from a domain's match value leaves that domain's window unchanged, whether it was armed or disarmed.
- R4: An event with `bcast_kind`=2'b10 (resume) disarms the windows of both domains at the next clock edge, whatever its action field, and `gate_en` drops after that edge.
- R5: `stop_link_n` is active low and is synchronized by two flops. A low level first sampled at edge k can raise `gate_en` no earlier than after edge k+1.
- R6: Releasing `stop_link_n` clears `gate_en` but keeps the windows armed. Driving it low again gates the armed domains with no new broadcast.
- R7: An active stop-link request with a disarmed window gives `gate_en` low for that domain.
- R8: The two domains are independent. Bit 0 of `gate_en` follows domain 0 (core grids) with its own match value. Bit 1 follows domain 1 (expansion-bus clock) with its own match value.
- R9: With `cfg_we`=1, `cfg_wdata` is written at the clock edge to the match value of domain `cfg_sel` (0 core, 1 expansion). A stop-grant in the same cycle as the write is compared against the old value.
- R10: An event with `bcast_valid`=0, or with `bcast_kind` 2'b00 or 2'b11, has no effect on either window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| stop_link_n | input | 1 | Asynchronous active-low stop-link request |
| bcast_valid | input | 1 | Decoded broadcast event present this cycle |
| bcast_kind | input | 2 | Event kind: 01 stop-grant, 10 resume, others ignored |
| bcast_action | input | 3 | System-management action field of the event |
| cfg_we | input | 1 | Match value write strobe |
| cfg_sel | input | 1 | Domain whose match value is written |
| cfg_wdata | input | 3 | Match value to write |
| gate_en | output | 2 | Per-domain clock gate enable (bit 0 core, bit 1 expansion) |

## Verification
The hardest situation to reach is a stop-grant that arrives in the same cycle as a write to that domain's match value. The event carries the new value, so the outcome shows only whether the comparison used the old value or the new one. The bench first programs a known value and asserts the stop-link request. It then issues the write and the matching event together and checks that the gate stays low. A second stop-grant with the same field then arms the window. The synchronizer latency is checked edge by edge, with the stop-link pin changed half a period before a known edge.

// File: rtl/pmcg_pkg.sv
package pmcg_pkg;
  typedef enum logic [1:0] {
    BC_NONE       = 2'b00,
    BC_STOP_GRANT = 2'b01,
    BC_RESUME     = 2'b10,
    BC_RSVD       = 2'b11
  } bcast_kind_e;
endpackage

// File: rtl/pmcg_sync.sv
module pmcg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pmcg_match_reg.sv
module pmcg_match_reg #(
  parameter int AW = 3,
  parameter logic [AW-1:0] RESET_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] match_o
);
  logic [AW-1:0] val_q;
  logic [AW-1:0] val_d;

  always_comb begin
    val_d = val_q;
    if (we) val_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= RESET_VAL;
    else        val_q <= val_d;
  end

  assign match_o = val_q;
endmodule

// File: rtl/pmcg_window.sv
module pmcg_window #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_grant,
  input  logic          ev_resume,
  input  logic [AW-1:0] action,
  input  logic [AW-1:0] match,
  input  logic          stop_act,
  output logic          win_o,
  output logic          gate_o
);
  logic win_q;
  logic win_d;
  logic hit;

  always_comb begin
    hit   = ev_grant && (action == match);
    win_d = win_q;
    if (ev_resume)  win_d = 1'b0;
    else if (hit)   win_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= 1'b0;
    else        win_q <= win_d;
  end

  assign win_o  = win_q;
  assign gate_o = win_q & stop_act;

  // R2
  grant_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_grant && (action == match)) |=> win_q);

  // R3
  miss_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_grant && (action != match) && !ev_resume) |=> $stable(win_q));

  // R4
  resume_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_resume |=> !win_q);
endmodule

// File: rtl/pmcg_gate_window.sv
module pmcg_gate_window #(
  parameter int AW = 3,
  parameter int ND = 2,
  parameter int SYNC_STAGES = 2,
  parameter int SW = (ND > 1) ? $clog2(ND) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stop_link_n,
  input  logic          bcast_valid,
  input  logic [1:0]    bcast_kind,
  input  logic [AW-1:0] bcast_action,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [ND-1:0] gate_en
);
  import pmcg_pkg::*;

  logic        stop_act;
  logic        ev_grant;
  logic        ev_resume;
  logic [ND-1:0] win;
  bcast_kind_e kind;

  pmcg_sync #(.STAGES(SYNC_STAGES)) u_stop_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (~stop_link_n),
    .sync_o  (stop_act)
  );

  always_comb begin
    kind      = bcast_kind_e'(bcast_kind);
    ev_grant  = bcast_valid && (kind == BC_STOP_GRANT);
    ev_resume = bcast_valid && (kind == BC_RESUME);
  end

  for (genvar d = 0; d < ND; d++) begin : g_dom
    logic          dom_we;
    logic [AW-1:0] dom_match;

    assign dom_we = cfg_we && (cfg_sel == SW'(d));

    pmcg_match_reg #(.AW(AW)) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (dom_we),
      .wdata   (cfg_wdata),
      .match_o (dom_match)
    );

    pmcg_window #(.AW(AW)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_grant  (ev_grant),
      .ev_resume (ev_resume),
      .action    (bcast_action),
      .match     (dom_match),
      .stop_act  (stop_act),
      .win_o     (win[d]),
      .gate_o    (gate_en[d])
    );

    // R5
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate_en[d] |-> $past(!stop_link_n, 2));

    // R7
    gate_needs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_en[d]) |-> (win[d] && !$past(!win[d] && !ev_grant)));
  end
endmodule

// File: tb/tb_pmcg_gate_window.sv
module tb_pmcg_gate_window;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  // fields: we sel wd[3] valid kind[2] act[3] stopn exp[2]
  localparam logic [13:0] VEC [NV] = '{
    {1'b1,1'b0,3'd5, 1'b0,2'b00,3'd0, 1'b1, 2'b00}, // R9 core=5
    {1'b1,1'b1,3'd2, 1'b0,2'b00,3'd0, 1'b1, 2'b00}, // R9 exp=2
    {1'b0,1'b0,3'd0, 1'b1,2'b01,3'd5, 1'b1, 2'b00}, // R2 arm core, no stop
    {1'b0,1'b0,3'd0, 1'b0,2'b00,3'd0, 1'b0, 2'b01}, // R2 stop -> gate core
    {1'b0,1'b0,3'd0, 1'b1,2'b01,3'd3, 1'b0, 2'b01}, // R3 miss
    {1'b0,1'b0,3'd0, 1'b1,2'b01,3'd2, 1'b0, 2'b11}, // R8 arm exp
    {1'b0,1'b0,3'd0, 1'b0,2'b00,3'd0, 1'b1, 2'b00}, // R6 release
    {1'b0,1'b0,3'd0, 1'b0,2'b00,3'd0, 1'b0, 2'b11}, // R6 regate
    {1'b0,1'b0,3'd0, 1'b1,2'b11,3'd0, 1'b0, 2'b11}, // R10 rsvd kind
    {1'b0,1'b0,3'd0, 1'b0,2'b10,3'd0, 1'b0, 2'b11}, // R10 valid low
    {1'b0,1'b0,3'd0, 1'b1,2'b10,3'd6, 1'b0, 2'b00}, // R4 resume
    {1'b0,1'b0,3'd0, 1'b1,2'b01,3'd2, 1'b0, 2'b10}, // R8 exp only
    {1'b0,1'b0,3'd0, 1'b1,2'b10,3'd2, 1'b0, 2'b00}  // R4 resume
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       stop_link_n;
  logic       bcast_valid;
  logic [1:0] bcast_kind;
  logic [2:0] bcast_action;
  logic       cfg_we;
  logic       cfg_sel;
  logic [2:0] cfg_wdata;
  logic [1:0] gate_en;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmcg_gate_window dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .stop_link_n  (stop_link_n),
    .bcast_valid  (bcast_valid),
    .bcast_kind   (bcast_kind),
    .bcast_action (bcast_action),
    .cfg_we       (cfg_we),
    .cfg_sel      (cfg_sel),
    .cfg_wdata    (cfg_wdata),
    .gate_en      (gate_en)
  );

  task automatic check(input string req, input logic [1:0] exp);
    checks++;
    if (gate_en !== exp) begin
      failures++;
      $display("FAIL %s gate_en actual=%b expected=%b", req, gate_en, exp);
    end
  endtask

  task automatic idle();
    bcast_valid = 1'b0; bcast_kind = 2'b00; bcast_action = 3'd0;
    cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = 3'd0;
  endtask

  task automatic bcast(input logic [1:0] k, input logic [2:0] a);
    @(negedge clk);
    bcast_valid = 1'b1; bcast_kind = k; bcast_action = a;
    @(negedge clk);
    idle();
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", 2'b00);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; stop_link_n = 1'b1;
    idle();
    repeat (3) @(negedge clk);
    check("R1", 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 2'b00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cfg_we       = VEC[i][13];
      cfg_sel      = VEC[i][12];
      cfg_wdata    = VEC[i][11:9];
      bcast_valid  = VEC[i][8];
      bcast_kind   = VEC[i][7:6];
      bcast_action = VEC[i][5:3];
      stop_link_n  = VEC[i][2];
      @(negedge clk);
      idle();
      repeat (2) @(negedge clk);
      check($sformatf("R2/R3/R4/R6/R8/R9/R10 vec%0d", i), VEC[i][1:0]);
    end

    // R5: synchronizer latency, core window armed, exp match 2
    stop_link_n = 1'b1;
    bcast(2'b01, 3'd5);
    settle();
    check("R7", 2'b00);
    stop_link_n = 1'b0;        // first sampled at next edge k
    @(negedge clk);
    check("R5 after edge k", 2'b00);
    @(negedge clk);
    check("R5 after edge k+1", 2'b01);

    // R2 timing: exp window arms, gate visible after the same edge
    @(negedge clk);
    bcast_valid = 1'b1; bcast_kind = 2'b01; bcast_action = 3'd2;
    @(negedge clk);
    idle();
    check("R2 one edge", 2'b11);

    // R4 timing: resume with stop still active
    @(negedge clk);
    bcast_valid = 1'b1; bcast_kind = 2'b10; bcast_action = 3'd5;
    @(negedge clk);
    idle();
    check("R4 one edge", 2'b00);

    // R9: write core=1 together with stop-grant act=1 -> old value 5 used
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 3'd1;
    bcast_valid = 1'b1; bcast_kind = 2'b01; bcast_action = 3'd1;
    @(negedge clk);
    idle();
    settle();
    check("R9 same-cycle old value", 2'b00);
    bcast(2'b01, 3'd1);
    settle();
    check("R9 new value", 2'b01);

    // R1: reset mid-operation clears windows and match values
    do_reset();
    settle();
    check("R1 after reset with stop low", 2'b00);
    bcast(2'b01, 3'd0);
    settle();
    check("R1 match values cleared", 2'b11);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end
endmodule